// File: doc/BRIEF.md
# Ring-Connected Systolic Absolute-Difference Array

This block is the pixel engine of a full-search block-matching motion estimator. It holds an N×N grid of processing elements, each keeping one template pixel and one reference pixel, and beside it an N×N grid of single-pixel shift registers. Each row of processing elements and the row of shift registers next to it form one ring of 2N cells. The ring can rotate by one cell in either direction, or every cell can take the value held in the cell above it. On every working cycle each processing element presents the absolute difference between its two pixels. A downstream adder tree and minimum search consume these values; both are outside this block.

A built-in sequencer steps the array through one search after a `start` pulse. First, N load cycles fill the grid from the top. Then "calculate" cycles, in which the differences are valid and the rings rotate, alternate with "input" cycles, in which one fresh reference row enters at the top. A sweep holds 2·DY such pairs. Between sweeps, N refill cycles shift the whole reference grid down, and the direction of rotation reverses for the next sweep. The sweeps therefore form a serpentine and the search position never has to rewind. Template pixels are loaded only during the load cycles and then stay in place.

Top module: `sad_ring_array`

## Requirements
- R1: After reset, `busy` is 0, `phase` is 2'b11 (idle), `absdiff_valid` is 0, and every stored pixel is 0, so every `absdiff` byte is 0.
- R2: A `start` seen while not busy raises `busy` and enters the load phase (`phase` 2'b00) for exactly N cycles. In each load cycle the template and reference grids shift down by one row. Row 0 takes `tmpl_row`, `ref_row` (processing-element columns) and `sr_row` (shift-register columns), and byte c of each bus feeds column c.
- R3: Each `absdiff` byte is |t − s| of its processing element, as an 8-bit unsigned value. Element (r,c) sits at bits [(r·N+c)·8 +: 8].
- R4: `absdiff_valid` is 1 exactly in calculate cycles (`phase` 2'b01 with `busy` high).
- R5: In a calculate cycle each row ring rotates by one cell. Ring position k is PE column k for k<N and SR column k−N for k≥N. In a rightward rotation cell k takes cell k−1, and cell 0 takes cell 2N−1. In a leftward rotation cell k takes cell k+1, and cell 2N−1 takes cell 0.
- R6: In an input cycle (`phase` 2'b10) the reference contents of the whole ring grid shift down one row, with row 0 loaded from `ref_row` and `sr_row`.
- R7: A sweep is 2·DY calculate/input pairs, always in that order. Between two sweeps there are N refill cycles (`phase` 2'b11 with `busy` high), each a downward shift as in R6, with `absdiff_valid` low.
- R8: The first sweep rotates rightward, and each refill reverses the direction of rotation.
- R9: After the last input cycle of the SWEEPS-th sweep, `busy` falls and `phase` reads 2'b11. While not busy and without `start`, the array holds its contents whatever the row inputs carry.
- R10: `start` has no effect while `busy` is high.
- R11: Template pixels change only in load cycles. `tmpl_row` is ignored during calculate, input and refill cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| tmpl_row | input | N·8 | One template row, byte c for column c |
| ref_row | input | N·8 | One reference row for the PE columns |
| sr_row | input | N·8 | One reference row for the shift-register columns |
| phase | output | 2 | 00 load, 01 calculate, 10 input, 11 refill/idle |
| busy | output | 1 | High while a search is in progress |
| absdiff_valid | output | 1 | Differences valid this cycle |
| absdiff | output | N·N·8 | Per-element absolute differences |

## Verification
The bench keeps its own model of the template grid and the ring grid, and compares every difference byte in every cycle of several searches. A swapped neighbour at the ring seam, or a ring that wraps over N cells instead of 2N, gives wrong bytes after the first calculate cycle. A missing reversal after a refill gives wrong bytes in the second sweep. Template patterns of all ones against references of all zeros, and the reverse, expose a subtraction that wraps instead of taking the absolute value. A template input that changes outside the load phase catches a design that reloads templates. A `start` held high through a sweep, and rows that keep changing after the search ends, catch restarts and drift. A reset in the middle of a load must return the block to the cleared idle state.

// File: rtl/sad_ring_pkg.sv
// Shared types for the ring-connected absolute-difference array.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sad_ring_pkg;
    // Externally visible phase encoding (also driven onto the phase port).
    typedef enum logic [1:0] {
        PH_INIT  = 2'b00,
        PH_CALC  = 2'b01,
        PH_INPUT = 2'b10,
        PH_IDLE  = 2'b11
    } phase_t;

    // Per-cycle movement applied to every pixel cell of the grid.
    typedef enum logic [1:0] {
        MV_HOLD  = 2'b00,
        MV_DOWN  = 2'b01,
        MV_RIGHT = 2'b10,
        MV_LEFT  = 2'b11
    } move_t;
endpackage

// File: rtl/sad_ring_seq.sv
// Phase sequencer: load (N cycles), then SWEEPS sweeps of 2*DY calc/input
// pairs, with N refill cycles between sweeps and a direction flip at each
// refill. Assumes N >= 2, DY >= 1, SWEEPS >= 1.
module sad_ring_seq
    import sad_ring_pkg::*;
#(
    parameter int N      = 4,
    parameter int DY     = 2,
    parameter int SWEEPS = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   busy,
    output move_t  move,
    output logic   tmpl_shift,
    output logic   valid
);
    localparam int PAIRS = 2 * DY;
    localparam int CW    = $clog2(N) + 1;
    localparam int PCW   = $clog2(PAIRS) + 1;
    localparam int SCW   = $clog2(SWEEPS) + 1;
    localparam logic [CW-1:0]  CNT_LAST   = CW'(N - 1);
    localparam logic [PCW-1:0] PAIR_LAST  = PCW'(PAIRS - 1);
    localparam logic [SCW-1:0] SWEEP_LAST = SCW'(SWEEPS - 1);

    phase_t         phase_q;
    logic           busy_q;
    logic           dir_q;
    logic [CW-1:0]  cnt_q;
    logic [PCW-1:0] pair_q;
    logic [SCW-1:0] sweep_q;

    // State advance for the search schedule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
            dir_q   <= 1'b0;
            cnt_q   <= '0;
            pair_q  <= '0;
            sweep_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= PH_INIT;
                dir_q   <= 1'b0;
                cnt_q   <= '0;
                pair_q  <= '0;
                sweep_q <= '0;
            end
        end else begin
            case (phase_q)
                PH_INIT: begin
                    if (cnt_q == CNT_LAST) begin
                        phase_q <= PH_CALC;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CALC: phase_q <= PH_INPUT;
                PH_INPUT: begin
                    if (pair_q == PAIR_LAST) begin
                        pair_q  <= '0;
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        if (sweep_q == SWEEP_LAST) begin
                            busy_q <= 1'b0;
                        end else begin
                            sweep_q <= sweep_q + 1'b1;
                        end
                    end else begin
                        pair_q  <= pair_q + 1'b1;
                        phase_q <= PH_CALC;
                    end
                end
                default: begin
                    if (cnt_q == CNT_LAST) begin
                        phase_q <= PH_CALC;
                        cnt_q   <= '0;
                        dir_q   <= ~dir_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Decode the grid movement and flags from the current phase.
    always_comb begin
        move       = MV_HOLD;
        tmpl_shift = 1'b0;
        valid      = 1'b0;
        if (busy_q) begin
            case (phase_q)
                PH_INIT: begin
                    move       = MV_DOWN;
                    tmpl_shift = 1'b1;
                end
                PH_CALC: begin
                    move  = dir_q ? MV_LEFT : MV_RIGHT;
                    valid = 1'b1;
                end
                default: move = MV_DOWN;
            endcase
        end
    end

    assign phase = phase_q;
    assign busy  = busy_q;
endmodule

// File: rtl/sad_ring_cell.sv
// One pixel register with a three-way source select (left, right, top).
// Used as the shift-register cell and as the reference path of each PE.
module sad_ring_cell
    import sad_ring_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  move_t         move,
    input  logic [PW-1:0] from_left,
    input  logic [PW-1:0] from_right,
    input  logic [PW-1:0] from_top,
    output logic [PW-1:0] q
);
    // Select the neighbour named by the current move, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (move)
                MV_RIGHT: q <= from_left;
                MV_LEFT:  q <= from_right;
                MV_DOWN:  q <= from_top;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/sad_ring_pe.sv
// Processing element: resident template pixel, movable reference pixel,
// and |t - s| via a PW+1 bit signed subtraction. Assumes unsigned pixels.
module sad_ring_pe
    import sad_ring_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  move_t         move,
    input  logic          tmpl_shift,
    input  logic [PW-1:0] t_top,
    input  logic [PW-1:0] s_left,
    input  logic [PW-1:0] s_right,
    input  logic [PW-1:0] s_top,
    output logic [PW-1:0] t_q,
    output logic [PW-1:0] s_q,
    output logic [PW-1:0] diff
);
    logic signed [PW:0] sub;
    logic signed [PW:0] neg;

    // Template pixel moves only during the load phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else if (tmpl_shift) begin
            t_q <= t_top;
        end
    end

    sad_ring_cell #(.PW(PW)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .move       (move),
        .from_left  (s_left),
        .from_right (s_right),
        .from_top   (s_top),
        .q          (s_q)
    );

    // Absolute difference of the two held pixels.
    always_comb begin
        sub  = $signed({1'b0, t_q}) - $signed({1'b0, s_q});
        neg  = -sub;
        diff = sub[PW] ? neg[PW-1:0] : sub[PW-1:0];
    end
endmodule

// File: rtl/sad_ring_array.sv
// Top: N rows, each a ring of N PEs followed by N shift-register cells,
// driven by the phase sequencer. Row 0 is fed from the row input buses.
module sad_ring_array
    import sad_ring_pkg::*;
#(
    parameter int N      = 4,
    parameter int PW     = 8,
    parameter int DY     = 2,
    parameter int SWEEPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*PW-1:0]   tmpl_row,
    input  logic [N*PW-1:0]   ref_row,
    input  logic [N*PW-1:0]   sr_row,
    output logic [1:0]        phase,
    output logic              busy,
    output logic              absdiff_valid,
    output logic [N*N*PW-1:0] absdiff
);
    localparam int RING = 2 * N;

    phase_t            seq_phase;
    move_t             move;
    logic              tmpl_shift;
    logic [PW-1:0]     ring      [N][RING];
    logic [PW-1:0]     top_s     [N][RING];
    logic [PW-1:0]     top_t     [N][N];
    logic [PW-1:0]     tmpl_grid [N][N];
    logic [N*N*PW-1:0] tmpl_flat;

    sad_ring_seq #(.N(N), .DY(DY), .SWEEPS(SWEEPS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase      (seq_phase),
        .busy       (busy),
        .move       (move),
        .tmpl_shift (tmpl_shift),
        .valid      (absdiff_valid)
    );

    assign phase = seq_phase;

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar k = 0; k < RING; k++) begin : g_cell
            // Source from above: input bus on row 0, upper row elsewhere.
            if (r == 0) begin : g_top_in
                if (k < N) begin : g_pe_in
                    assign top_s[r][k] = ref_row[k*PW +: PW];
                    assign top_t[r][k] = tmpl_row[k*PW +: PW];
                end else begin : g_sr_in
                    assign top_s[r][k] = sr_row[(k-N)*PW +: PW];
                end
            end else begin : g_top_up
                assign top_s[r][k] = ring[r-1][k];
                if (k < N) begin : g_pe_up
                    assign top_t[r][k] = tmpl_grid[r-1][k];
                end
            end

            if (k < N) begin : g_pe
                sad_ring_pe #(.PW(PW)) u_pe (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .move       (move),
                    .tmpl_shift (tmpl_shift),
                    .t_top      (top_t[r][k]),
                    .s_left     (ring[r][(k+RING-1)%RING]),
                    .s_right    (ring[r][(k+1)%RING]),
                    .s_top      (top_s[r][k]),
                    .t_q        (tmpl_grid[r][k]),
                    .s_q        (ring[r][k]),
                    .diff       (absdiff[(r*N+k)*PW +: PW])
                );
                assign tmpl_flat[(r*N+k)*PW +: PW] = tmpl_grid[r][k];
            end else begin : g_sr
                sad_ring_cell #(.PW(PW)) u_sr (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .move       (move),
                    .from_left  (ring[r][(k+RING-1)%RING]),
                    .from_right (ring[r][(k+1)%RING]),
                    .from_top   (top_s[r][k]),
                    .q          (ring[r][k])
                );
            end
        end
    end
endmodule

// File: rtl/sad_ring_chk.sv
// Protocol checker for sad_ring_array, attached by bind. Observes ports
// plus the resident template grid; counts phase run lengths itself.
module sad_ring_chk
    import sad_ring_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        phase,
    input logic              busy,
    input logic              absdiff_valid,
    input logic [N*N*PW-1:0] absdiff,
    input logic [N*N*PW-1:0] tmpl_flat
);
    localparam int CW = $clog2(N) + 2;
    localparam logic [CW-1:0] NL = CW'(N);

    logic [CW-1:0] run_init;
    logic [CW-1:0] run_idle;

    // Length of the current load and refill runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_init <= '0;
            run_idle <= '0;
        end else begin
            run_init <= (busy && phase == PH_INIT) ? run_init + 1'b1 : '0;
            run_idle <= (busy && phase == PH_IDLE) ? run_idle + 1'b1 : '0;
        end
    end

    p_start_enters_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && phase == PH_INIT));

    p_init_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_INIT) |-> (run_init < NL));

    p_valid_only_calc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        absdiff_valid |-> (busy && phase == PH_CALC));

    p_calc_has_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_CALC) |-> absdiff_valid);

    p_calc_then_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_CALC) |=> (busy && phase == PH_INPUT));

    p_refill_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_IDLE) |-> (run_idle < NL));

    p_hold_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(absdiff));

    p_tmpl_resident_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_INIT) |=> $stable(tmpl_flat));
endmodule

bind sad_ring_array sad_ring_chk #(.N(N), .PW(PW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .phase         (phase),
    .busy          (busy),
    .absdiff_valid (absdiff_valid),
    .absdiff       (absdiff),
    .tmpl_flat     (tmpl_flat)
);

// File: tb/tb_sad_ring_array.sv
module tb_sad_ring_array;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int PW     = 8;
    localparam int DY     = 2;
    localparam int SWEEPS = 3;
    localparam int PAIRS  = 2 * DY;
    localparam int RING   = 2 * N;
    // Stimulus table: {seed[7:0], pattern kind[1:0], hold start during sweep 0}
    localparam int NRUNS = 4;
    localparam logic [10:0] RUNS [NRUNS] = '{
        {8'd17,  2'd0, 1'b0},
        {8'd200, 2'd0, 1'b1},
        {8'd3,   2'd1, 1'b0},
        {8'd99,  2'd2, 1'b0}
    };

    logic              clk;
    logic              rst_n;
    logic              start;
    logic [N*PW-1:0]   tmpl_row;
    logic [N*PW-1:0]   ref_row;
    logic [N*PW-1:0]   sr_row;
    logic [1:0]        phase;
    logic              busy;
    logic              absdiff_valid;
    logic [N*N*PW-1:0] absdiff;

    sad_ring_array #(.N(N), .PW(PW), .DY(DY), .SWEEPS(SWEEPS)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .tmpl_row      (tmpl_row),
        .ref_row       (ref_row),
        .sr_row        (sr_row),
        .phase         (phase),
        .busy          (busy),
        .absdiff_valid (absdiff_valid),
        .absdiff       (absdiff)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;
    int gcyc     = 0;
    logic [7:0] cur_seed;
    logic [1:0] cur_kind;
    logic       start_level;
    logic [7:0] mt [N][N];
    logic [7:0] mr [N][RING];

    function automatic logic [7:0] pix(int which, int col);
        case (cur_kind)
            2'd1: return (which == 0) ? 8'hFF : 8'h00;
            2'd2: return (which == 0) ? 8'h00 : ((which == 1) ? 8'hFF : 8'(col * 60 + gcyc));
            default: return 8'((cur_seed * 37 + gcyc * 13 + col * 29 + which * 71 + gcyc * col * 5) & 255);
        endcase
    endfunction

    task automatic model_clear();
        for (int r = 0; r < N; r++) begin
            for (int k = 0; k < RING; k++) mr[r][k] = 8'h00;
            for (int c = 0; c < N; c++) mt[r][c] = 8'h00;
        end
    endtask

    // mv: 0 hold, 1 down with template, 2 down reference only, 3 right, 4 left
    task automatic model_move(int mv);
        logic [7:0] tmp [RING];
        if (mv == 1 || mv == 2) begin
            for (int r = N - 1; r > 0; r--) begin
                for (int k = 0; k < RING; k++) mr[r][k] = mr[r-1][k];
                if (mv == 1) for (int c = 0; c < N; c++) mt[r][c] = mt[r-1][c];
            end
            for (int k = 0; k < RING; k++)
                mr[0][k] = (k < N) ? ref_row[k*PW +: PW] : sr_row[(k-N)*PW +: PW];
            if (mv == 1) for (int c = 0; c < N; c++) mt[0][c] = tmpl_row[c*PW +: PW];
        end else if (mv == 3 || mv == 4) begin
            for (int r = 0; r < N; r++) begin
                for (int k = 0; k < RING; k++) tmp[k] = mr[r][k];
                for (int k = 0; k < RING; k++)
                    mr[r][k] = (mv == 3) ? tmp[(k + RING - 1) % RING] : tmp[(k + 1) % RING];
            end
        end
    endtask

    task automatic check_state(string tag, logic [1:0] ep, logic eb, logic ev);
        logic [N*N*PW-1:0] expv;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                expv[(r*N+c)*PW +: PW] = (mt[r][c] > mr[r][c]) ? mt[r][c] - mr[r][c] : mr[r][c] - mt[r][c];
        checks++;
        if (phase !== ep || busy !== eb || absdiff_valid !== ev) begin
            failures++;
            $display("FAIL %s control: phase=%0d busy=%0b valid=%0b expected phase=%0d busy=%0b valid=%0b",
                     tag, phase, busy, absdiff_valid, ep, eb, ev);
        end
        checks++;
        if (absdiff !== expv) begin
            failures++;
            $display("FAIL %s absdiff: got %h expected %h", tag, absdiff, expv);
        end
    endtask

    // One clock: drive fresh rows, check the current state, advance the model.
    task automatic cycle(string tag, logic [1:0] ep, logic eb, logic ev, int mv);
        @(negedge clk);
        gcyc++;
        start = start_level;
        for (int c = 0; c < N; c++) begin
            tmpl_row[c*PW +: PW] = pix(0, c);
            ref_row[c*PW +: PW]  = pix(1, c);
            sr_row[c*PW +: PW]   = pix(2, c);
        end
        check_state(tag, ep, eb, ev);
        model_move(mv);
    endtask

    task automatic run_search(logic hold_start);
        int dir;
        start_level = 1'b1;
        cycle("R1 R9 idle before start", 2'b11, 1'b0, 1'b0, 0);
        start_level = hold_start;
        for (int i = 0; i < N; i++) cycle("R2 load", 2'b00, 1'b1, 1'b0, 1);
        dir = 0;
        for (int sw = 0; sw < SWEEPS; sw++) begin
            for (int p = 0; p < PAIRS; p++) begin
                cycle(dir == 0 ? "R3 R5 R8 R10 calc right" : "R3 R4 R5 R8 calc left",
                      2'b01, 1'b1, 1'b1, dir == 0 ? 3 : 4);
                cycle("R6 R11 input", 2'b10, 1'b1, 1'b0, 2);
            end
            start_level = 1'b0;
            if (sw < SWEEPS - 1) begin
                for (int i = 0; i < N; i++) cycle("R7 R11 refill", 2'b11, 1'b1, 1'b0, 2);
                dir ^= 1;
            end
        end
        for (int i = 0; i < 3; i++) cycle("R9 hold after end", 2'b11, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired busy=%0b expected 0", busy);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        start_level = 1'b0;
        tmpl_row = '1;
        ref_row = '0;
        sr_row = '1;
        cur_seed = 8'd0;
        cur_kind = 2'd0;
        model_clear();
        repeat (2) @(negedge clk);
        check_state("R1 reset", 2'b11, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NRUNS; i++) begin
            cur_seed = RUNS[i][10:3];
            cur_kind = RUNS[i][2:1];
            run_search(RUNS[i][0]);
        end

        // Reset in the middle of a load returns to the cleared idle state.
        cur_seed = 8'd77;
        cur_kind = 2'd0;
        start_level = 1'b1;
        cycle("R2 start", 2'b11, 1'b0, 1'b0, 0);
        start_level = 1'b0;
        cycle("R2 load", 2'b00, 1'b1, 1'b0, 1);
        cycle("R2 load", 2'b00, 1'b1, 1'b0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        @(negedge clk);
        check_state("R1 mid-run reset", 2'b11, 1'b0, 1'b0);
        rst_n = 1'b1;

        cur_seed = 8'd141;
        run_search(1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule